// File: doc/BRIEF.md
# Saturating Complex Add/Subtract/Negate/Conjugate Unit

This block is one arithmetic slot of a statically scheduled datapath. It performs four operations on complex operands whose real and imaginary parts are 16-bit two's-complement numbers. A 2-bit operation select drives the unit directly, with no instruction decoding. Negation and conjugation read only the first operand. Each lane (real and imaginary) has one saturating adder. When a lane's true result is above the largest representable value, the adder clamps it to that limit and raises an overflow flag. When the result is below the smallest representable value, the adder clamps it to that limit and raises an underflow flag.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. A single output register gives one cycle of latency. Back-pressure works as follows. While a result is held with `res_ready` low, `opd_ready` stays low and the held result and flags do not change. When `res_ready` is high, a new operand set can be accepted in the same cycle that the old result leaves, so one operation per cycle is sustained.

Top module: `cplx_sat_alu`

## Requirements
- R1: With `opd_op` = 2'b00 the result is A+B, computed separately on the real and imaginary lanes.
- R2: With `opd_op` = 2'b01 the result is A−B on both lanes.
- R3: With `opd_op` = 2'b10 the result is −A on both lanes, and the B operand has no effect on the result or the flags.
- R4: With `opd_op` = 2'b11 the result is the conjugate of A: the real part passes through unchanged, the imaginary part is negated, and B has no effect.
- R5: When a lane's exact result exceeds 32767, that lane outputs 32767 and its overflow flag is 1.
- R6: When a lane's exact result is below −32768, that lane outputs −32768 and its underflow flag is 1.
- R7: Negating −32768, whether through opcode 2'b10 or the imaginary lane of opcode 2'b11, gives 32767 with that lane's overflow flag set.
- R8: A result that fits exactly, including 32767 and −32768 themselves, leaves both flags of that lane at 0. Overflow and underflow are never both set on one lane.
- R9: An operand set accepted on a clock edge (`opd_valid` and `opd_ready` both high) appears with `res_valid` high after that edge. The latency is exactly one cycle.
- R10: While `res_valid` is high and `res_ready` is low, `opd_ready` is low and the result and flags hold. A result is only replaced once it has been taken.
- R11: During and directly after reset, `res_valid` is 0, `opd_ready` is 1, and the result and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opd_valid | input | 1 | Operand set present |
| opd_ready | output | 1 | Unit can take an operand set this cycle |
| opd_op | input | 2 | Operation: 00 add, 01 subtract, 10 negate A, 11 conjugate A |
| opd_a_re | input | 16 | Operand A real part, signed |
| opd_a_im | input | 16 | Operand A imaginary part, signed |
| opd_b_re | input | 16 | Operand B real part, signed |
| opd_b_im | input | 16 | Operand B imaginary part, signed |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_re | output | 16 | Result real part, signed, saturated |
| res_im | output | 16 | Result imaginary part, signed, saturated |
| res_re_ovf | output | 1 | Real lane clamped to the maximum |
| res_re_unf | output | 1 | Real lane clamped to the minimum |
| res_im_ovf | output | 1 | Imaginary lane clamped to the maximum |
| res_im_unf | output | 1 | Imaginary lane clamped to the minimum |

## Verification
The bench concentrates on the edges of the 16-bit range. A sum that lands exactly on 32767 or −32768 must not raise a flag; a design that compares with the wrong inclusivity would flag it or clamp it. Negating −32768 through either the negate or the conjugate path must give 32767 with overflow; a design that wraps would return −32768 with no flag. Subtracting −32768 from zero must be detected as overflow, which catches a design that forms −B in 16 bits before adding. A stall with a second operand set waiting must keep the held result intact and then deliver the waiting result; a design with a wrong ready equation would either lose that set or overwrite the unread result.

// File: rtl/cplx_alu_pkg.sv
`timescale 1ns/1ps
package cplx_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_NEG  = 2'b10,
    OP_CONJ = 2'b11
  } cplx_op_e;

  localparam int NUM_LANES = 2;
  localparam int LANE_RE   = 0;
  localparam int LANE_IM   = 1;
endpackage

// File: rtl/cplx_operand_sel.sv
`timescale 1ns/1ps
// Routes operands to the per-lane adders so that one adder pair serves
// all four operations: x + y or x - y on each lane.
module cplx_operand_sel
  import cplx_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  cplx_op_e             op,
  input  logic signed [W-1:0]  a_re,
  input  logic signed [W-1:0]  a_im,
  input  logic signed [W-1:0]  b_re,
  input  logic signed [W-1:0]  b_im,
  output logic signed [W-1:0]  x_re,
  output logic signed [W-1:0]  y_re,
  output logic                 sub_re,
  output logic signed [W-1:0]  x_im,
  output logic signed [W-1:0]  y_im,
  output logic                 sub_im
);
  always_comb begin
    x_re = a_re; y_re = b_re; sub_re = 1'b0;
    x_im = a_im; y_im = b_im; sub_im = 1'b0;
    unique case (op)
      OP_ADD: ;
      OP_SUB: begin
        sub_re = 1'b1;
        sub_im = 1'b1;
      end
      OP_NEG: begin
        x_re = '0; y_re = a_re; sub_re = 1'b1;
        x_im = '0; y_im = a_im; sub_im = 1'b1;
      end
      OP_CONJ: begin
        y_re = '0;
        x_im = '0; y_im = a_im; sub_im = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_lane_adder.sv
`timescale 1ns/1ps
// One lane: exact sum in W+2 bits, then clamp to the W-bit signed range.
module sat_lane_adder #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  input  logic                sub,
  output logic signed [W-1:0] sum,
  output logic                ovf,
  output logic                unf
);
  localparam int EW = W + 2;

  logic signed [EW-1:0] x_ext, y_ext, exact;
  logic [1:0]           guard;

  always_comb begin
    x_ext = {{2{x[W-1]}}, x};
    y_ext = {{2{y[W-1]}}, y};
    exact = sub ? (x_ext - y_ext) : (x_ext + y_ext);
    guard = exact[EW-2:W-1];
    ovf   = !exact[EW-1] && (guard != 2'b00);
    unf   =  exact[EW-1] && (guard != 2'b11);
    if (ovf)      sum = {1'b0, {(W-1){1'b1}}};
    else if (unf) sum = {1'b1, {(W-1){1'b0}}};
    else          sum = exact[W-1:0];
  end
endmodule

// File: rtl/cplx_sat_alu.sv
`timescale 1ns/1ps
module cplx_sat_alu
  import cplx_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         opd_valid,
  output logic         opd_ready,
  input  logic [1:0]   opd_op,
  input  logic [W-1:0] opd_a_re,
  input  logic [W-1:0] opd_a_im,
  input  logic [W-1:0] opd_b_re,
  input  logic [W-1:0] opd_b_im,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_re,
  output logic [W-1:0] res_im,
  output logic         res_re_ovf,
  output logic         res_re_unf,
  output logic         res_im_ovf,
  output logic         res_im_unf
);
  logic signed [W-1:0] lx [NUM_LANES];
  logic signed [W-1:0] ly [NUM_LANES];
  logic                lsub [NUM_LANES];
  logic signed [W-1:0] lsum [NUM_LANES];
  logic                lovf [NUM_LANES];
  logic                lunf [NUM_LANES];

  logic accept;

  cplx_operand_sel #(.W(W)) sel_i (
    .op     (cplx_op_e'(opd_op)),
    .a_re   (opd_a_re),
    .a_im   (opd_a_im),
    .b_re   (opd_b_re),
    .b_im   (opd_b_im),
    .x_re   (lx[LANE_RE]),
    .y_re   (ly[LANE_RE]),
    .sub_re (lsub[LANE_RE]),
    .x_im   (lx[LANE_IM]),
    .y_im   (ly[LANE_IM]),
    .sub_im (lsub[LANE_IM])
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    sat_lane_adder #(.W(W)) add_i (
      .x   (lx[g]),
      .y   (ly[g]),
      .sub (lsub[g]),
      .sum (lsum[g]),
      .ovf (lovf[g]),
      .unf (lunf[g])
    );
  end

  assign opd_ready = !res_valid || res_ready;
  assign accept    = opd_valid && opd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_re     <= '0;
      res_im     <= '0;
      res_re_ovf <= 1'b0;
      res_re_unf <= 1'b0;
      res_im_ovf <= 1'b0;
      res_im_unf <= 1'b0;
    end else begin
      if (opd_ready) res_valid <= opd_valid;
      if (accept) begin
        res_re     <= lsum[LANE_RE];
        res_im     <= lsum[LANE_IM];
        res_re_ovf <= lovf[LANE_RE];
        res_re_unf <= lunf[LANE_RE];
        res_im_ovf <= lovf[LANE_IM];
        res_im_unf <= lunf[LANE_IM];
      end
    end
  end
endmodule

// File: rtl/cplx_sat_alu_chk.sv
`timescale 1ns/1ps
module cplx_sat_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         opd_valid,
  input logic         opd_ready,
  input logic [1:0]   opd_op,
  input logic [W-1:0] opd_a_re,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] res_re,
  input logic [W-1:0] res_im,
  input logic         res_re_ovf,
  input logic         res_re_unf,
  input logic         res_im_ovf,
  input logic         res_im_unf
);
  localparam logic [W-1:0] VMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};

  a_r5_ovf_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_re_ovf || res_im_ovf)) |->
      ((!res_re_ovf || res_re == VMAX) && (!res_im_ovf || res_im == VMAX)));

  a_r6_unf_at_min: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_re_unf || res_im_unf)) |->
      ((!res_re_unf || res_re == VMIN) && (!res_im_unf || res_im == VMIN)));

  a_r7_neg_min: assert property (@(posedge clk) disable iff (!rst_n)
    (opd_valid && opd_ready && opd_op == 2'b10 && opd_a_re == VMIN) |=>
      (res_re == VMAX && res_re_ovf));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_re_ovf && res_re_unf) && !(res_im_ovf && res_im_unf));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (opd_valid && opd_ready) |=> res_valid);

  a_r10_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !opd_ready);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_re) && $stable(res_im) &&
       $stable(res_re_ovf) && $stable(res_im_ovf)));
endmodule

bind cplx_sat_alu cplx_sat_alu_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .opd_valid  (opd_valid),
  .opd_ready  (opd_ready),
  .opd_op     (opd_op),
  .opd_a_re   (opd_a_re),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_re     (res_re),
  .res_im     (res_im),
  .res_re_ovf (res_re_ovf),
  .res_re_unf (res_re_unf),
  .res_im_ovf (res_im_ovf),
  .res_im_unf (res_im_unf)
);

// File: tb/cplx_sat_alu_tb_top.sv
`timescale 1ns/1ps
module cplx_sat_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opd_valid = 1'b0;
  logic        opd_ready;
  logic [1:0]  opd_op = 2'b00;
  logic [15:0] opd_a_re = '0, opd_a_im = '0, opd_b_re = '0, opd_b_im = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_re, res_im;
  logic        res_re_ovf, res_re_unf, res_im_ovf, res_im_unf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  cplx_sat_alu dut_i (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] ar, ai, br, bi, er, ei;
    logic [3:0]  fl; // {re_ovf, re_unf, im_ovf, im_unf}
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 16'd100,    16'd200,    16'd50,     -16'sd30,   16'd150,    16'd170,    4'b0000},
    '{2'b01, 16'd100,    16'd200,    16'd50,     -16'sd30,   16'd50,     16'd230,    4'b0000},
    '{2'b10, 16'd1234,   -16'sd5,    16'd7777,   16'd7777,   -16'sd1234, 16'd5,      4'b0000},
    '{2'b11, 16'd300,    -16'sd400,  16'd999,    16'd999,    16'd300,    16'd400,    4'b0000},
    '{2'b00, 16'd30000,  -16'sd30000,16'd10000,  -16'sd10000,16'h7FFF,   16'h8000,   4'b1001},
    '{2'b01, -16'sd30000,16'd30000,  16'd10000,  -16'sd10000,16'h8000,   16'h7FFF,   4'b0110},
    '{2'b10, 16'h8000,   16'h7FFF,   16'd0,      16'd0,      16'h7FFF,   16'h8001,   4'b1000},
    '{2'b11, 16'h8000,   16'h8000,   16'd0,      16'd0,      16'h8000,   16'h7FFF,   4'b0010},
    '{2'b00, 16'h7FFF,   16'h8000,   16'd0,      16'd0,      16'h7FFF,   16'h8000,   4'b0000},
    '{2'b01, 16'd0,      -16'sd1,    16'h8000,   16'h7FFF,   16'h7FFF,   16'h8000,   4'b1000},
    '{2'b00, 16'h7FFF,   16'h8000,   16'd1,      -16'sd1,    16'h7FFF,   16'h8000,   4'b1001},
    '{2'b10, 16'd0,      -16'sd1,    16'h8000,   16'h8000,   16'd0,      16'd1,      4'b0000}
  };

  function automatic string req_of(int i);
    case (i)
      0: return "R1";        1: return "R2";
      2: return "R3";        3: return "R4";
      4: return "R5/R6";     5: return "R5/R6";
      6: return "R7";        7: return "R7";
      8: return "R8";        9: return "R5/R8";
      10: return "R5/R6";    default: return "R3";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    opd_op = v.op; opd_a_re = v.ar; opd_a_im = v.ai;
    opd_b_re = v.br; opd_b_im = v.bi;
  endtask

  task automatic check_res(string req, vec_t v);
    check(req, "res_re", {16'd0, res_re}, {16'd0, v.er});
    check(req, "res_im", {16'd0, res_im}, {16'd0, v.ei});
    check(req, "flags", {28'd0, res_re_ovf, res_re_unf, res_im_ovf, res_im_unf}, {28'd0, v.fl});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t held;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "res_valid", {31'd0, res_valid}, 32'd0);
    check("R11", "opd_ready", {31'd0, opd_ready}, 32'd1);
    check("R11", "res_re", {16'd0, res_re}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "res_valid after release", {31'd0, res_valid}, 32'd0);

    // Table walk, one operation per cycle
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      opd_valid = 1'b1;
      @(negedge clk);
      opd_valid = 1'b0;
      check("R9", "res_valid", {31'd0, res_valid}, 32'd1);
      check_res(req_of(i), VECS[i]);
    end
    @(negedge clk);
    check("R9", "res_valid idle", {31'd0, res_valid}, 32'd0);

    // R10: stall with a second set waiting
    res_ready = 1'b0;
    drive(VECS[4]);
    opd_valid = 1'b1;
    @(negedge clk);
    drive(VECS[6]);
    for (int k = 0; k < 3; k++) begin
      check("R10", "opd_ready in stall", {31'd0, opd_ready}, 32'd0);
      check("R10", "res_valid in stall", {31'd0, res_valid}, 32'd1);
      check_res("R10", VECS[4]);
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    opd_valid = 1'b0;
    check("R10", "res_valid after drain", {31'd0, res_valid}, 32'd1);
    check_res("R10", VECS[6]);
    @(negedge clk);
    check("R10", "res_valid empty", {31'd0, res_valid}, 32'd0);

    // R3/R4: B has no effect
    held = VECS[3];
    held.br = 16'h8000; held.bi = 16'h7FFF;
    drive(held); opd_valid = 1'b1;
    @(negedge clk);
    opd_valid = 1'b0;
    check_res("R4", held);
    held = VECS[2];
    held.br = 16'h7FFF; held.bi = 16'h8000;
    drive(held); opd_valid = 1'b1;
    @(negedge clk);
    opd_valid = 1'b0;
    check_res("R3", held);

    // R11: reset mid-stream clears the result
    drive(VECS[0]); opd_valid = 1'b1;
    @(negedge clk);
    opd_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11", "res_valid in reset", {31'd0, res_valid}, 32'd0);
    check("R11", "res_im in reset", {16'd0, res_im}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule